// File: doc/BRIEF.md
# Symmetrical Space Vector Compare Value Generator

This block turns a rotating voltage angle and a modulation magnitude into the three phase compare values for a center-aligned three-phase PWM timer. The timer's half-period is 255 counts. On every update strobe the block adds a frequency word to a 16-bit angle that spans six sectors. It then splits the angle into a sector number and an index within the sector. Both dwell times come from one shared sine table: one time is read at the index, the other at the mirrored index. Each dwell time is scaled by the magnitude, and the zero-vector time is split evenly around the two dwell times.

The block sits between the control loop, which supplies the frequency word and the magnitude, and the PWM timer's compare preload registers. The timer's update event drives the strobe. The three results and a one-cycle valid pulse arrive a fixed three clocks later, well before the next update. In each sector one phase takes the low value, one takes the high value, and one takes the low value plus a dwell time. Within a period, the inverter therefore moves between its states one leg at a time.

Top module: `svm_cmp_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first result, `cmp_u`, `cmp_v` and `cmp_w` are 0 and `cmp_valid` is 0.
- R2: The internal angle starts at 0. Each sampled `upd_stb` adds `freq_inc` (at most 0x4000) to it. When the sum exceeds 0xBFFF, 0xC000 is subtracted, so the angle never leaves 0x0000..0xBFFF.
- R3: The sector number is angle bits 15:13 (0..5). The in-sector index k is bits 12:5. Bits 4:0 have no effect on the outputs.
- R4: The table entry is T[j] = round(255*sin((255.5-j)*pi/768)) for j = 0..255. The dwell times are ta = (T[k]*m)>>8 and tb = (T[255-k]*m)>>8, where m is the `mag_in` value sampled together with `upd_stb`.
- R5: The low value is L = (~(ta+tb) over 8 bits)>>1 and the high value is H = ~L = 255-L. The middle value is L+ta in even sectors and L+tb in odd sectors.
- R6: The phase assignment (U,V,W) per sector is: 0:(L,mid,H); 1:(L,H,mid); 2:(mid,H,L); 3:(H,mid,L); 4:(H,L,mid); 5:(mid,L,H). Every output is within one count of the value given by R4 and R5.
- R7: `cmp_valid` goes high for exactly one cycle, set by the third rising clock edge counting the edge that samples `upd_stb`. The compare outputs change only together with that pulse and hold between pulses.
- R8: With a sampled magnitude of 0, all three compare values lie in 127..128, so no line-to-line voltage is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | Update event; advances the angle and starts a computation |
| freq_inc | input | 16 | Angle increment applied per update (at most 0x4000) |
| mag_in | input | 8 | Modulation magnitude, 256 = full table scale |
| cmp_u | output | 8 | Compare value for phase U |
| cmp_v | output | 8 | Compare value for phase V |
| cmp_w | output | 8 | Compare value for phase W |
| cmp_valid | output | 1 | One-cycle pulse marking new compare values |

## Verification
The assertions assume that `freq_inc` never exceeds 0x4000, so one subtraction always brings the angle back into range. They also assume that `upd_stb` is held low while reset is active. The bench keeps every increment at or below 0x4000 and leaves the strobe low through each reset. It spaces its strobes at least five cycles apart, so every valid pulse can be matched to a single update. After each strobe it changes `mag_in`, which shows that the magnitude is captured at the strobe and not read later.

// File: rtl/svm_pkg.sv
// Shared types and elaboration-time helpers for the space vector compare generator.
// Assumes a six-sector angle and three output phases.
package svm_pkg;

    localparam int SVM_SEC_W  = 3;
    localparam int SVM_SEC_NUM = 6;
    localparam int SVM_PHASES = 3;

    // Role that a phase plays inside the current sector.
    typedef enum logic [1:0] {
        ROLE_LO  = 2'd0,
        ROLE_HI  = 2'd1,
        ROLE_MID = 2'd2
    } role_e;

    // Picks one role out of the three (U, V, W) for phase index ph.
    function automatic role_e pick_role(input int ph, input role_e ru, input role_e rv, input role_e rw);
        if (ph == 0) return ru;
        if (ph == 1) return rv;
        return rw;
    endfunction

    // Rotating role table: one low, one high and one middle phase per sector.
    function automatic role_e phase_role(input logic [SVM_SEC_W-1:0] sec, input int ph);
        case (sec)
            3'd0:    return pick_role(ph, ROLE_LO,  ROLE_MID, ROLE_HI);
            3'd1:    return pick_role(ph, ROLE_LO,  ROLE_HI,  ROLE_MID);
            3'd2:    return pick_role(ph, ROLE_MID, ROLE_HI,  ROLE_LO);
            3'd3:    return pick_role(ph, ROLE_HI,  ROLE_MID, ROLE_LO);
            3'd4:    return pick_role(ph, ROLE_HI,  ROLE_LO,  ROLE_MID);
            3'd5:    return pick_role(ph, ROLE_MID, ROLE_LO,  ROLE_HI);
            default: return ROLE_LO;
        endcase
    endfunction

    // Elaboration-time sine entry: round(full*sin((depth-0.5-j)*pi/(3*depth))).
    // Uses a Q24 Taylor series, which is accurate far below one count for angles up to pi/3.
    function automatic int sine_entry(input int j, input int idx_w, input int cnt_w);
        longint pi_q, depth, x, x2, term, acc, full;
        pi_q  = 64'd52707179;
        depth = longint'(1) << idx_w;
        full  = (longint'(1) << cnt_w) - 1;
        x     = (2 * depth - 1 - 2 * longint'(j)) * pi_q / (6 * depth);
        x2    = (x * x) >>> 24;
        term  = x;
        acc   = x;
        for (int n = 1; n <= 4; n++) begin
            term = (term * x2) >>> 24;
            term = -term / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return int'((acc * full + (longint'(1) << 23)) >>> 24);
    endfunction

endpackage

// File: rtl/svm_angle_acc.sv
// Angle accumulator: on each update strobe, adds the increment and wraps into the six-sector span.
// Also captures the magnitude together with the strobe. Assumes inc_i never exceeds one sector pair
// (sum minus span always lands inside the span).
module svm_angle_acc #(
    parameter int ANG_W = 16,
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [ANG_W-1:0] inc_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [ANG_W-1:0] angle_o,
    output logic [MAG_W-1:0] mag_o,
    output logic             vld_o
);
    import svm_pkg::*;

    localparam int            SPAN   = SVM_SEC_NUM << (ANG_W - SVM_SEC_W);
    localparam logic [ANG_W:0] SPAN_X = SPAN[ANG_W:0];

    logic [ANG_W:0]   sum_w;
    logic [ANG_W:0]   wrap_w;
    logic [ANG_W-1:0] next_w;

    // Add the increment and fold the result back into the legal angle span.
    always_comb begin
        sum_w  = {1'b0, angle_o} + {1'b0, inc_i};
        wrap_w = (sum_w >= SPAN_X) ? (sum_w - SPAN_X) : sum_w;
        next_w = wrap_w[ANG_W-1:0];
    end

    // Advance the angle, capture the magnitude and flag the first pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            angle_o <= '0;
            mag_o   <= '0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= stb_i;
            if (stb_i) begin
                angle_o <= next_w;
                mag_o   <= mag_i;
            end
        end
    end

    logic unused_top;
    assign unused_top = wrap_w[ANG_W];

endmodule

// File: rtl/svm_dwell_calc.sv
// Dwell time stage: decodes sector and in-sector index, reads the shared sine table at the
// index and at its mirror, and scales both by the magnitude (top bits of the product).
// Assumes the table's peak entries sum to at most the half-period.
module svm_dwell_calc #(
    parameter int ANG_W = 16,
    parameter int IDX_W = 8,
    parameter int CNT_W = 8,
    parameter int MAG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [ANG_W-1:0]         angle_i,
    input  logic [MAG_W-1:0]         mag_i,
    output logic [CNT_W-1:0]         ta_o,
    output logic [CNT_W-1:0]         tb_o,
    output logic [svm_pkg::SVM_SEC_W-1:0] sec_o,
    output logic                     vld_o
);
    import svm_pkg::*;

    localparam int DEPTH  = 1 << IDX_W;
    localparam int LOW_W  = ANG_W - SVM_SEC_W - IDX_W;
    localparam int PROD_W = CNT_W + MAG_W;

    logic [CNT_W-1:0] lut_w [DEPTH];

    // Constant sine table, one entry per in-sector index.
    for (genvar j = 0; j < DEPTH; j++) begin : g_lut
        localparam int ENTRY = sine_entry(j, IDX_W, CNT_W);
        assign lut_w[j] = ENTRY[CNT_W-1:0];
    end

    logic [SVM_SEC_W-1:0] sec_w;
    logic [IDX_W-1:0]     idx_w;
    logic [CNT_W-1:0]     ta_raw;
    logic [CNT_W-1:0]     tb_raw;
    logic [PROD_W-1:0]    prod_a;
    logic [PROD_W-1:0]    prod_b;

    // Decode the angle, read the table forward and mirrored, and scale both reads.
    always_comb begin
        sec_w  = angle_i[ANG_W-1 -: SVM_SEC_W];
        idx_w  = angle_i[ANG_W-SVM_SEC_W-1 -: IDX_W];
        ta_raw = lut_w[idx_w];
        tb_raw = lut_w[~idx_w];
        prod_a = {{MAG_W{1'b0}}, ta_raw} * {{CNT_W{1'b0}}, mag_i};
        prod_b = {{MAG_W{1'b0}}, tb_raw} * {{CNT_W{1'b0}}, mag_i};
    end

    // Register the scaled dwell times and the sector for the compare stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_o  <= '0;
            tb_o  <= '0;
            sec_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                ta_o  <= prod_a[PROD_W-1 -: CNT_W];
                tb_o  <= prod_b[PROD_W-1 -: CNT_W];
                sec_o <= sec_w;
            end
        end
    end

    logic unused_bits;
    if (LOW_W > 0) begin : g_low
        assign unused_bits = ^{angle_i[LOW_W-1:0], prod_a[MAG_W-1:0], prod_b[MAG_W-1:0]};
    end else begin : g_nolow
        assign unused_bits = ^{prod_a[MAG_W-1:0], prod_b[MAG_W-1:0]};
    end

endmodule

// File: rtl/svm_cmp_map.sv
// Compare stage: splits the zero-vector time evenly by bitwise inversion against the
// all-ones half-period and hands the low, high and middle values to the phases by sector.
// Assumes ta_i + tb_i fits in CNT_W bits.
module svm_cmp_map #(
    parameter int CNT_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   vld_i,
    input  logic [CNT_W-1:0]                       ta_i,
    input  logic [CNT_W-1:0]                       tb_i,
    input  logic [svm_pkg::SVM_SEC_W-1:0]          sec_i,
    output logic [svm_pkg::SVM_PHASES-1:0][CNT_W-1:0] cmp_o,
    output logic                                   vld_o
);
    import svm_pkg::*;

    logic [CNT_W-1:0] sum_w;
    logic [CNT_W-1:0] lo_w;
    logic [CNT_W-1:0] hi_w;
    logic [CNT_W-1:0] mid_w;
    logic [SVM_PHASES-1:0][CNT_W-1:0] nxt_w;

    // Half of the zero-vector time, its mirror, and the middle edge for this sector.
    always_comb begin
        sum_w = ta_i + tb_i;
        lo_w  = (~sum_w) >> 1;
        hi_w  = ~lo_w;
        mid_w = lo_w + (sec_i[0] ? tb_i : ta_i);
    end

    // Per-phase selection of the value that matches the phase's role in the sector.
    for (genvar p = 0; p < SVM_PHASES; p++) begin : g_phase
        role_e role_w;
        assign role_w = phase_role(sec_i, p);
        always_comb begin
            case (role_w)
                ROLE_LO: nxt_w[p] = lo_w;
                ROLE_HI: nxt_w[p] = hi_w;
                default: nxt_w[p] = mid_w;
            endcase
        end
    end

    // Register the compare values and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                cmp_o <= nxt_w;
            end
        end
    end

endmodule

// File: rtl/svm_cmp_gen.sv
// Top of the symmetrical space vector compare generator: angle accumulator, dwell time
// stage and compare stage in a three-register pipeline. Assumes update strobes are single
// pulses and freq_inc stays at or below one third of the angle span.
module svm_cmp_gen #(
    parameter int ANG_W = 16,
    parameter int IDX_W = 8,
    parameter int CNT_W = 8,
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_stb,
    input  logic [ANG_W-1:0] freq_inc,
    input  logic [MAG_W-1:0] mag_in,
    output logic [CNT_W-1:0] cmp_u,
    output logic [CNT_W-1:0] cmp_v,
    output logic [CNT_W-1:0] cmp_w,
    output logic             cmp_valid
);
    import svm_pkg::*;

    logic [ANG_W-1:0]     angle_w;
    logic [MAG_W-1:0]     mag_w;
    logic                 acc_vld;
    logic [CNT_W-1:0]     ta_w;
    logic [CNT_W-1:0]     tb_w;
    logic [SVM_SEC_W-1:0] sec_w;
    logic                 dwell_vld;
    logic [SVM_PHASES-1:0][CNT_W-1:0] cmp_w_all;

    svm_angle_acc #(.ANG_W(ANG_W), .MAG_W(MAG_W)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (upd_stb),
        .inc_i   (freq_inc),
        .mag_i   (mag_in),
        .angle_o (angle_w),
        .mag_o   (mag_w),
        .vld_o   (acc_vld)
    );

    svm_dwell_calc #(.ANG_W(ANG_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .MAG_W(MAG_W)) i_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (acc_vld),
        .angle_i (angle_w),
        .mag_i   (mag_w),
        .ta_o    (ta_w),
        .tb_o    (tb_w),
        .sec_o   (sec_w),
        .vld_o   (dwell_vld)
    );

    svm_cmp_map #(.CNT_W(CNT_W)) i_map (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (dwell_vld),
        .ta_i  (ta_w),
        .tb_i  (tb_w),
        .sec_i (sec_w),
        .cmp_o (cmp_w_all),
        .vld_o (cmp_valid)
    );

    assign cmp_u = cmp_w_all[0];
    assign cmp_v = cmp_w_all[1];
    assign cmp_w = cmp_w_all[2];

endmodule

// File: rtl/svm_cmp_chk.sv
// Property checker for svm_cmp_gen, attached by bind. Assumes upd_stb is low during reset
// and freq_inc never exceeds one third of the angle span.
module svm_cmp_chk #(
    parameter int ANG_W = 16,
    parameter int CNT_W = 8,
    parameter int MAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_stb,
    input logic [MAG_W-1:0] mag_in,
    input logic [ANG_W-1:0] angle,
    input logic [CNT_W-1:0] cmp_u,
    input logic [CNT_W-1:0] cmp_v,
    input logic [CNT_W-1:0] cmp_w,
    input logic             cmp_valid
);
    import svm_pkg::*;

    localparam int              SPAN   = SVM_SEC_NUM << (ANG_W - SVM_SEC_W);
    localparam logic [ANG_W:0]  SPAN_X = SPAN[ANG_W:0];
    localparam logic [CNT_W:0]  FULL_X = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] MID_LO = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MID_HI = {1'b1, {(CNT_W-1){1'b0}}};

    AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, angle} < SPAN_X); // R2

    AST_VALID_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> $past(upd_stb, 3)); // R7

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |-> ($stable(cmp_u) && $stable(cmp_v) && $stable(cmp_w))); // R7

    AST_HI_LO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (({1'b0, cmp_u} + {1'b0, cmp_v}) == FULL_X ||
                       ({1'b0, cmp_v} + {1'b0, cmp_w}) == FULL_X ||
                       ({1'b0, cmp_u} + {1'b0, cmp_w}) == FULL_X)); // R5

    AST_ZERO_MAG_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && $past(mag_in, 3) == '0) |->
        (cmp_u >= MID_LO && cmp_u <= MID_HI &&
         cmp_v >= MID_LO && cmp_v <= MID_HI &&
         cmp_w >= MID_LO && cmp_w <= MID_HI)); // R8

endmodule

bind svm_cmp_gen svm_cmp_chk #(.ANG_W(ANG_W), .CNT_W(CNT_W), .MAG_W(MAG_W)) i_svm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_stb   (upd_stb),
    .mag_in    (mag_in),
    .angle     (angle_w),
    .cmp_u     (cmp_u),
    .cmp_v     (cmp_v),
    .cmp_w     (cmp_w),
    .cmp_valid (cmp_valid)
);

// File: tb/test_svm_cmp_gen.sv
// Self-checking bench for svm_cmp_gen: a vector table walked by one loop, then directed tests.
module test_svm_cmp_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_stb = 1'b0;
    logic [15:0] freq_inc = '0;
    logic [7:0]  mag_in = '0;
    logic [7:0]  cmp_u, cmp_v, cmp_w;
    logic        cmp_valid;

    int checks = 0;
    int fails  = 0;
    int model_angle = 0;
    bit done = 1'b0;

    // {increment, magnitude}
    localparam logic [23:0] VECS [NVEC] = '{
        {16'h0000, 8'd200}, {16'h1000, 8'd255}, {16'h1800, 8'd180}, {16'h2000, 8'd255},
        {16'h2345, 8'd128}, {16'h2000, 8'd255}, {16'h2000, 8'd90},  {16'h2000, 8'd255},
        {16'h3FFF, 8'd230}, {16'h4000, 8'd255}, {16'h3500, 8'd64},  {16'h0BFF, 8'd255}
    };

    svm_cmp_gen i_svm_cmp_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_stb   (upd_stb),
        .freq_inc  (freq_inc),
        .mag_in    (mag_in),
        .cmp_u     (cmp_u),
        .cmp_v     (cmp_v),
        .cmp_w     (cmp_w),
        .cmp_valid (cmp_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int tab(input int j);
        real a;
        a = (255.5 - real'(j)) * PI / 768.0;
        return $rtoi(255.0 * $sin(a) + 0.5);
    endfunction

    // Expected compare values from the requirement formulas.
    function automatic void expect_cmp(input int ang, input int m, output int eu, output int ev, output int ew);
        int s, k, ta, tb, lo, hi, md;
        s  = (ang >> 13) & 7;
        k  = (ang >> 5) & 255;
        ta = (tab(k) * m) >> 8;
        tb = (tab(255 - k) * m) >> 8;
        lo = (255 - ta - tb) >> 1;
        hi = 255 - lo;
        md = lo + (((s % 2) == 1) ? tb : ta);
        case (s)
            0: begin eu = lo; ev = md; ew = hi; end
            1: begin eu = lo; ev = hi; ew = md; end
            2: begin eu = md; ev = hi; ew = lo; end
            3: begin eu = hi; ev = md; ew = lo; end
            4: begin eu = hi; ev = lo; ew = md; end
            default: begin eu = md; ev = lo; ew = hi; end
        endcase
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input int act, input int exp);
        int d;
        checks++;
        d = act - exp;
        if (d > 1 || d < -1) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset cmp_u", int'(cmp_u), 0);
        check_eq("R1 reset cmp_v", int'(cmp_v), 0);
        check_eq("R1 reset cmp_w", int'(cmp_w), 0);
        check_eq("R1 reset cmp_valid", int'(cmp_valid), 0);
        rst_n = 1'b1;
        model_angle = 0;
    endtask

    // One update: strobe, track the angle, check the valid pulse, values and hold.
    task automatic apply(input logic [15:0] inc, input logic [7:0] m, output int u, output int v, output int w);
        int eu, ev, ew;
        @(negedge clk);
        upd_stb = 1'b1; freq_inc = inc; mag_in = m;
        @(negedge clk);
        upd_stb = 1'b0; freq_inc = '0; mag_in = ~m;
        model_angle = model_angle + int'(inc);
        if (model_angle > 'hBFFF) model_angle = model_angle - 'hC000;
        @(negedge clk);
        check_eq("R7 valid not early", int'(cmp_valid), 0);
        @(negedge clk);
        check_eq("R7 valid pulse", int'(cmp_valid), 1);
        u = int'(cmp_u); v = int'(cmp_v); w = int'(cmp_w);
        expect_cmp(model_angle, int'(m), eu, ev, ew);
        check_near("R2 R4 R5 R6 cmp_u", u, eu);
        check_near("R2 R4 R5 R6 cmp_v", v, ev);
        check_near("R2 R4 R5 R6 cmp_w", w, ew);
        @(negedge clk);
        check_eq("R7 valid one cycle", int'(cmp_valid), 0);
        check_eq("R7 hold cmp_u", int'(cmp_u), u);
    endtask

    initial begin : main
        int u, v, w, u2, v2, w2;
        repeat (2) @(negedge clk);
        check_eq("R1 cmp_valid in reset", int'(cmp_valid), 0);
        do_reset();
        check_eq("R1 idle after reset", int'(cmp_u) + int'(cmp_v) + int'(cmp_w), 0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][23:8], VECS[i][7:0], u, v, w);
        end

        // R8: zero magnitude gives equal phases near mid-scale
        apply(16'h0321, 8'd0, u, v, w);
        check_eq("R8 cmp_u mid", int'(u >= 127 && u <= 128), 1);
        check_eq("R8 cmp_v mid", int'(v >= 127 && v <= 128), 1);
        check_eq("R8 cmp_w mid", int'(w >= 127 && w <= 128), 1);

        // R7: outputs hold with no strobe
        repeat (6) @(negedge clk);
        check_eq("R7 long hold cmp_v", int'(cmp_v), v);
        check_eq("R7 long hold cmp_w", int'(cmp_w), w);

        // R3: low five angle bits have no effect
        do_reset();
        apply(16'h0A00, 8'd200, u, v, w);
        do_reset();
        apply(16'h0A1F, 8'd200, u2, v2, w2);
        check_eq("R3 low bits cmp_u", u2, u);
        check_eq("R3 low bits cmp_v", v2, v);
        check_eq("R3 low bits cmp_w", w2, w);

        // R2: last legal angle, then wrap exactly to zero
        do_reset();
        apply(16'h4000, 8'd255, u, v, w);
        apply(16'h4000, 8'd255, u, v, w);
        apply(16'h3FFF, 8'd255, u, v, w);
        apply(16'h0001, 8'd255, u, v, w);
        check_eq("R2 wrap to zero", model_angle, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule